// File: doc/BRIEF.md
# Byte-wide ROM bootstrap loader

This block sits next to a processor's reset logic. While reset is held it samples a 3-bit operating-mode code from the mode pins. From the active mode it derives two things: the program address at which the core starts after reset, and whether internal program RAM is mapped in. When the code asks for a boot from external ROM, the block keeps the core halted and copies a program out of a byte-wide ROM into internal program RAM. Three consecutive ROM bytes form one 24-bit word. Every ROM access is stretched by a fixed number of wait states so that slow parts can be used. When the last word has been written, the block changes the mode to single-chip (code 000), raises a done flag and releases the core at address 0x0000.

Software may write a new mode code at any time. The write changes the memory map one cycle later. It does not halt the core and does not start a new copy. A copy only ever starts after a hardware reset.

Top module: `rom_boot_loader`

## Requirements
- R1: The mode code is captured on every clock edge while `rst_n` is low and is held after reset is released. Later changes on `mode_pins` have no effect. The code is ordered {MC,MB,MA}. Code 001 starts a ROM copy. Every other code sets `core_run` high in the first cycle after the first clock edge with `rst_n` high, with no ROM access and with `boot_done` low.
- R2: `reset_vector` is 0xE000 when the active mode is 010 and 0x0000 for every other code, including after a copy. `pram_en` is low only in mode 011. Codes 100, 101, 110 and 111 behave as mode 000.
- R3: During a copy, each ROM access holds `rom_rd` high with a stable `rom_addr` for WAIT_STATES+1 cycles (16 by default). Accesses follow each other with no gap, at addresses 0 to 3*NUM_WORDS-1 in ascending order. `rom_rd` is never high outside a copy.
- R4: Word n is packed with the least significant byte first: the byte at ROM address 3n goes to bits 7:0, the byte at 3n+1 to bits 15:8, and the byte at 3n+2 to bits 23:16.
- R5: A copy makes exactly NUM_WORDS single-cycle `ram_we` pulses, one per completed 3-byte group, at `ram_addr` 0 to NUM_WORDS-1 in order. Word n is written in cycle 48n+49 after the first edge with reset released (default timing).
- R6: `core_run` stays low for the whole copy. It rises the cycle after the final write (cycle 48*NUM_WORDS+2 with default timing), together with `boot_done`. At that point the active mode is 000.
- R7: A software mode write (`sw_mode_we` high for one cycle) changes `mode_q`, `reset_vector` and `pram_en` from the following cycle on. It never changes `core_run` and never starts, stops or restarts a copy. If the write lands in the cycle in which the copy completes, the forced switch to mode 000 takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| mode_pins | input | 3 | Mode code {MC,MB,MA}, sampled while reset is low |
| sw_mode_we | input | 1 | Software mode write strobe |
| sw_mode_data | input | 3 | Mode code written by software |
| rom_addr | output | ROM_AW | External ROM byte address |
| rom_rd | output | 1 | External ROM read strobe, high for the whole access |
| rom_data | input | BYTE_W | External ROM byte |
| ram_we | output | 1 | Internal program RAM write strobe |
| ram_addr | output | RAM_AW | Internal program RAM word address |
| ram_wdata | output | 3*BYTE_W | Assembled program word |
| mode_q | output | 3 | Active operating mode |
| pram_en | output | 1 | Internal program RAM mapped in |
| reset_vector | output | 16 | Start address for the core |
| core_run | output | 1 | Core released to fetch |
| boot_done | output | 1 | A ROM copy has completed |

## Verification
The bench builds the block with NUM_WORDS=4 and keeps the default 15 wait states and 8-bit bytes. A full copy then takes under two hundred cycles, so each of the eight mode codes can be run from reset within one run. The small word count also puts the final group and the release of the core within reach. Every one of the twelve accesses can be measured against its 16-cycle length, and software writes can be placed both in the middle of a copy and after it.

// File: rtl/boot_pkg.sv
package boot_pkg;

  localparam int PC_W = 16;

  typedef enum logic [2:0] {
    MODE_SINGLE   = 3'b000,
    MODE_ROMBOOT  = 3'b001,
    MODE_EXPANDED = 3'b010,
    MODE_DEV      = 3'b011,
    MODE_RSV_A    = 3'b100,
    MODE_HOSTBOOT = 3'b101,
    MODE_SERBOOT  = 3'b110,
    MODE_RSV_B    = 3'b111
  } op_mode_e;

  typedef enum logic [1:0] {
    ST_DECIDE,
    ST_LOAD,
    ST_DRAIN,
    ST_RUN
  } ldr_state_e;

  localparam logic [PC_W-1:0] VEC_LOW  = 16'h0000;
  localparam logic [PC_W-1:0] VEC_HIGH = 16'hE000;

  // Start address selected by a mode code.
  function automatic logic [PC_W-1:0] vector_for(input logic [2:0] m);
    return (m == MODE_EXPANDED) ? VEC_HIGH : VEC_LOW;
  endfunction

  // Internal program RAM is mapped in for every code except development mode.
  function automatic logic pram_on(input logic [2:0] m);
    return (m != MODE_DEV);
  endfunction

  // Only the ROM-boot code makes this block copy anything.
  function automatic logic wants_rom_load(input logic [2:0] m);
    return (m == MODE_ROMBOOT);
  endfunction

endpackage

// File: rtl/boot_mode_reg.sv
module boot_mode_reg
  import boot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode_pins,
  input  logic            sw_we,
  input  logic [2:0]      sw_mode,
  input  logic            force_single,
  output logic [2:0]      mode_q,
  output logic [PC_W-1:0] reset_vector,
  output logic            pram_en
);

  always_ff @(posedge clk) begin
    if (!rst_n)            mode_q <= mode_pins;
    else if (force_single) mode_q <= MODE_SINGLE;
    else if (sw_we)        mode_q <= sw_mode;
  end

  always_comb begin
    reset_vector = vector_for(mode_q);
    pram_en      = pram_on(mode_q);
  end

  // R7: a software write lands one cycle later
  assert_remap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !force_single) |=> (mode_q == $past(sw_mode)));

  // R6: leaving the copy always ends in single-chip mode
  assert_exit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_single |=> (mode_q == MODE_SINGLE));

endmodule

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
  parameter int WAIT_STATES = 15,
  localparam int CW = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic access_done
);

  localparam logic [CW-1:0] LAST = CW'(WAIT_STATES);

  logic [CW-1:0] cnt;

  assign access_done = active && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) cnt <= '0;
    else if (access_done)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  generate
    if (WAIT_STATES > 0) begin : g_gap
      // R3: two accesses cannot both end on neighbouring cycles
      assert_access_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        access_done |=> !access_done);
    end
  endgenerate

endmodule

// File: rtl/boot_byte_packer.sv
module boot_byte_packer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 3,
  localparam int WORD_W    = BYTE_W * LANES,
  localparam int LOW_LANES = LANES - 1,
  localparam int SEL_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_q
);

  logic [SEL_W-1:0]  sel;
  logic [BYTE_W-1:0] stash [LOW_LANES];
  logic [WORD_W-1:0] next_word;
  logic              group_end;

  assign group_end = byte_valid && (sel == SEL_W'(LOW_LANES));

  // Lower lanes come from the stash, the top lane from the byte arriving now.
  always_comb begin
    next_word = '0;
    for (int i = 0; i < LOW_LANES; i++)
      next_word[i*BYTE_W +: BYTE_W] = stash[i];
    next_word[LOW_LANES*BYTE_W +: BYTE_W] = byte_in;
  end

  generate
    for (genvar g = 0; g < LOW_LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n)                                  stash[g] <= '0;
        else if (byte_valid && sel == SEL_W'(g))     stash[g] <= byte_in;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel        <= '0;
      word_valid <= 1'b0;
      word_q     <= '0;
    end else begin
      word_valid <= 1'b0;
      if (group_end) begin
        word_q     <= next_word;
        word_valid <= 1'b1;
        sel        <= '0;
      end else if (byte_valid) begin
        sel <= sel + 1'b1;
      end
    end
  end

  // R4: the last byte of a group lands in the top lane
  assert_top_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    group_end |=> (word_valid && word_q[WORD_W-1 -: BYTE_W] == $past(byte_in)));

endmodule

// File: rtl/rom_boot_loader.sv
module rom_boot_loader
  import boot_pkg::*;
#(
  parameter int ROM_AW         = 16,
  parameter int BYTE_W         = 8,
  parameter int BYTES_PER_WORD = 3,
  parameter int NUM_WORDS      = 512,
  parameter int WAIT_STATES    = 15,
  localparam int WORD_W = BYTE_W * BYTES_PER_WORD,
  localparam int RAM_AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_pins,
  input  logic              sw_mode_we,
  input  logic [2:0]        sw_mode_data,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd,
  input  logic [BYTE_W-1:0] rom_data,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic [2:0]        mode_q,
  output logic              pram_en,
  output logic [PC_W-1:0]   reset_vector,
  output logic              core_run,
  output logic              boot_done
);

  localparam int TOTAL_BYTES = NUM_WORDS * BYTES_PER_WORD;
  localparam logic [ROM_AW-1:0] LAST_BYTE_ADDR = ROM_AW'(TOTAL_BYTES - 1);

  ldr_state_e        state, state_nx;
  logic [ROM_AW-1:0] byte_addr;
  logic [RAM_AW-1:0] word_idx;
  logic              load_active;
  logic              access_done;
  logic              last_byte;
  logic              finish_evt;
  logic              word_valid;
  logic [WORD_W-1:0] word_q;

  assign load_active = (state == ST_LOAD);
  assign last_byte   = (byte_addr == LAST_BYTE_ADDR);
  assign finish_evt  = (state == ST_DRAIN);

  boot_mode_reg u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_pins    (mode_pins),
    .sw_we        (sw_mode_we),
    .sw_mode      (sw_mode_data),
    .force_single (finish_evt),
    .mode_q       (mode_q),
    .reset_vector (reset_vector),
    .pram_en      (pram_en)
  );

  boot_wait_timer #(.WAIT_STATES(WAIT_STATES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (load_active),
    .access_done (access_done)
  );

  boot_byte_packer #(.BYTE_W(BYTE_W), .LANES(BYTES_PER_WORD)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (access_done),
    .byte_in    (rom_data),
    .word_valid (word_valid),
    .word_q     (word_q)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_DECIDE: state_nx = wants_rom_load(mode_q) ? ST_LOAD : ST_RUN;
      ST_LOAD:   if (access_done && last_byte) state_nx = ST_DRAIN;
      ST_DRAIN:  state_nx = ST_RUN;
      default:   state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_DECIDE;
      byte_addr <= '0;
      word_idx  <= '0;
      boot_done <= 1'b0;
    end else begin
      state <= state_nx;
      if (access_done) byte_addr <= byte_addr + 1'b1;
      if (word_valid)  word_idx  <= word_idx + 1'b1;
      if (finish_evt)  boot_done <= 1'b1;
    end
  end

  assign rom_addr  = byte_addr;
  assign rom_rd    = load_active;
  assign ram_we    = word_valid;
  assign ram_addr  = word_idx;
  assign ram_wdata = word_q;
  assign core_run  = (state == ST_RUN);

  // R3: address and strobe hold for the whole access
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && !access_done) |=> (rom_rd && $stable(rom_addr)));

  // R3: the next access follows at the next byte address
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && access_done && !last_byte) |=> (rom_rd && rom_addr == $past(rom_addr) + 1'b1));

  // R6: a running core sees no copy traffic
  assert_quiet_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> (!rom_rd && !ram_we));

  // R5: the final word is written in the completion cycle
  assert_last_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |-> ram_we);

  // R6: release after a copy finds mode 000
  assert_done_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_run) && boot_done) |-> (mode_q == MODE_SINGLE));

  // R1: non-boot codes release the core at once
  assert_direct_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECIDE && !wants_rom_load(mode_q)) |=> (core_run && !boot_done));

endmodule

// File: tb/rom_boot_loader_tb.sv
module rom_boot_loader_tb;

  localparam int N      = 4;
  localparam int WS     = 15;
  localparam int ROM_AW = 16;
  localparam int RAM_AW = 2;
  localparam int ACC    = WS + 1;
  localparam int BYTES  = 3 * N;

  // {mode[2:0], vector[15:0], pram_en, loads}
  localparam logic [20:0] VTAB [8] = '{
    {3'b000, 16'h0000, 1'b1, 1'b0},
    {3'b001, 16'h0000, 1'b1, 1'b1},
    {3'b010, 16'hE000, 1'b1, 1'b0},
    {3'b011, 16'h0000, 1'b0, 1'b0},
    {3'b100, 16'h0000, 1'b1, 1'b0},
    {3'b101, 16'h0000, 1'b1, 1'b0},
    {3'b110, 16'h0000, 1'b1, 1'b0},
    {3'b111, 16'h0000, 1'b1, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        mode_pins = 3'b000;
  logic              sw_mode_we = 1'b0;
  logic [2:0]        sw_mode_data = 3'b000;
  logic [ROM_AW-1:0] rom_addr;
  logic              rom_rd;
  logic [7:0]        rom_data;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [23:0]       ram_wdata;
  logic [2:0]        mode_q;
  logic              pram_en;
  logic [15:0]       reset_vector;
  logic              core_run;
  logic              boot_done;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
    return 8'(a * 37 + 90) ^ a[15:8];
  endfunction

  function automatic logic [23:0] expect_word(input int n);
    return {rom_byte(ROM_AW'(3*n+2)), rom_byte(ROM_AW'(3*n+1)), rom_byte(ROM_AW'(3*n))};
  endfunction

  assign rom_data = rom_byte(rom_addr);

  rom_boot_loader #(
    .ROM_AW(ROM_AW), .BYTE_W(8), .BYTES_PER_WORD(3),
    .NUM_WORDS(N), .WAIT_STATES(WS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
    .sw_mode_we(sw_mode_we), .sw_mode_data(sw_mode_data),
    .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_data(rom_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .mode_q(mode_q), .pram_en(pram_en), .reset_vector(reset_vector),
    .core_run(core_run), .boot_done(boot_done)
  );

  // monitor state, cleared by do_reset
  int cyc, rd_total, last_addr, wr_count, last_wr_cyc, first_run;
  bit order_bad, overlap;
  int rd_cnt [64];
  logic [RAM_AW-1:0] wr_addr [16];
  logic [23:0]       wr_data [16];

  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (rom_rd) begin
        rd_total = rd_total + 1;
        if (rom_addr < 64) rd_cnt[rom_addr] = rd_cnt[rom_addr] + 1;
        if (int'(rom_addr) != last_addr) begin
          if (int'(rom_addr) != last_addr + 1) order_bad = 1'b1;
          last_addr = int'(rom_addr);
        end
        if (core_run) overlap = 1'b1;
      end
      if (ram_we) begin
        if (wr_count < 16) begin
          wr_addr[wr_count] = ram_addr;
          wr_data[wr_count] = ram_wdata;
        end
        wr_count = wr_count + 1;
        last_wr_cyc = cyc;
        if (core_run) overlap = 1'b1;
      end
      if (core_run && first_run == 0) first_run = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_monitor();
    cyc = 0; rd_total = 0; last_addr = -1; wr_count = 0;
    last_wr_cyc = 0; first_run = 0; order_bad = 1'b0; overlap = 1'b0;
    for (int i = 0; i < 64; i++) rd_cnt[i] = 0;
  endtask

  task automatic do_reset(input logic [2:0] m);
    rst_n = 1'b0;
    mode_pins = m;
    sw_mode_we = 1'b0;
    repeat (3) step();
    clear_monitor();
    rst_n = 1'b1;
  endtask

  task automatic wait_run();
    for (int i = 0; i < ACC * BYTES + 20; i++) begin
      step();
      if (core_run) break;
    end
  endtask

  task automatic sw_write(input logic [2:0] m);
    sw_mode_we = 1'b1;
    sw_mode_data = m;
    step();
    sw_mode_we = 1'b0;
  endtask

  task automatic check_copy(input string tag);
    check(rd_total == ACC * BYTES, "R3", {tag, " total read cycles"}, rd_total, ACC * BYTES);
    for (int a = 0; a < BYTES; a++)
      check(rd_cnt[a] == ACC, "R3", {tag, " access length"}, rd_cnt[a], ACC);
    check(!order_bad, "R3", {tag, " address order"}, order_bad, 0);
    check(wr_count == N, "R5", {tag, " write count"}, wr_count, N);
    for (int w = 0; w < N; w++) begin
      check(wr_addr[w] == RAM_AW'(w), "R5", {tag, " write address"}, wr_addr[w], w);
      check(wr_data[w] == expect_word(w), "R4", {tag, " packed word"}, wr_data[w], expect_word(w));
    end
    check(last_wr_cyc == ACC * BYTES + 1, "R5", {tag, " final write cycle"}, last_wr_cyc, ACC * BYTES + 1);
    check(first_run == ACC * BYTES + 2, "R6", {tag, " release cycle"}, first_run, ACC * BYTES + 2);
    check(!overlap, "R6", {tag, " core halted during copy"}, overlap, 0);
    check(boot_done, "R6", {tag, " done flag"}, boot_done, 1);
    check(mode_q == 3'b000, "R6", {tag, " exit mode"}, mode_q, 0);
    check(reset_vector == 16'h0000, "R2", {tag, " exit vector"}, reset_vector, 0);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    clear_monitor();
    // reset state
    mode_pins = 3'b001;
    repeat (3) step();
    check(!core_run, "R1", "core_run in reset", core_run, 0);
    check(!rom_rd, "R3", "rom_rd in reset", rom_rd, 0);
    check(!ram_we, "R5", "ram_we in reset", ram_we, 0);
    check(!boot_done, "R1", "boot_done in reset", boot_done, 0);

    // table of mode codes
    for (int e = 0; e < 8; e++) begin
      logic [2:0]  m;
      logic [15:0] vec;
      logic        pe, ld;
      {m, vec, pe, ld} = VTAB[e];
      do_reset(m);
      if (ld) begin
        wait_run();
        check_copy("table");
      end else begin
        step();
        check(core_run, "R1", "direct release", core_run, 1);
        check(cyc == 1, "R1", "release cycle", cyc, 1);
        check(!boot_done, "R1", "no done flag", boot_done, 0);
        check(mode_q == m, "R1", "captured mode", mode_q, m);
        check(reset_vector == vec, "R2", "vector", reset_vector, vec);
        check(pram_en == pe, "R2", "pram_en", pram_en, pe);
        // pins changed after reset are ignored
        mode_pins = ~m;
        repeat (20) step();
        check(mode_q == m, "R1", "pins ignored after reset", mode_q, m);
        check(reset_vector == vec, "R1", "vector kept after pin change", reset_vector, vec);
        check(rd_total == 0, "R1", "no ROM access", rd_total, 0);
        check(wr_count == 0, "R1", "no RAM write", wr_count, 0);
      end
    end

    // software write in the middle of a copy
    do_reset(3'b001);
    repeat (50) step();
    sw_mode_we = 1'b1;
    sw_mode_data = 3'b010;
    check(reset_vector == 16'h0000, "R7", "no change in write cycle", reset_vector, 0);
    step();
    sw_mode_we = 1'b0;
    check(reset_vector == 16'hE000, "R7", "vector after write", reset_vector, 16'hE000);
    check(mode_q == 3'b010, "R7", "mode after write", mode_q, 3'b010);
    check(!core_run, "R7", "core still halted", core_run, 0);
    check(rom_rd, "R7", "copy continues", rom_rd, 1);
    wait_run();
    check_copy("swmid");

    // software writes after the core runs
    sw_write(3'b011);
    check(!pram_en, "R7", "pram off after write", pram_en, 0);
    check(core_run, "R7", "core keeps running", core_run, 1);
    sw_write(3'b001);
    check(mode_q == 3'b001, "R7", "boot code written", mode_q, 3'b001);
    repeat (40) step();
    check(rd_total == ACC * BYTES, "R7", "no restart of copy", rd_total, ACC * BYTES);
    check(core_run, "R7", "core not halted", core_run, 1);
    check(boot_done, "R7", "done flag kept", boot_done, 1);
    sw_write(3'b010);
    check(reset_vector == 16'hE000, "R2", "vector after run-time write", reset_vector, 16'hE000);
    check(pram_en, "R2", "pram on in mode 010", pram_en, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule